// File: doc/BRIEF.md
# Periodic Divider with Edge-Triggered Restart

This block divides its clock by a programmable amount. A down counter starts from a programmed period value, steps towards zero on every enabled clock, and on the terminal cycle reloads the period value and raises a one-cycle output pulse. With a period value of D, pulses repeat every D + 1 enabled clocks, so the block serves as a frequency divider or a periodic tick source. The period register is 14 bits wide. A narrow mode uses only its low 8 bits.

An asynchronous restart input can also restart the period. It passes through a two-flop synchroniser and then an edge picker. A two-bit select chooses which edges count: none, rising, falling or both. A selected edge reloads the counter and forces the output high for exactly one clock. The next pulse then follows a full period later. A new period value takes effect only at the next reload or restart, so a count already under way is never cut short.

Top module: `cdiv_period_gen`

## Requirements
- R1: While `rst_ni` is low, `pulse_o` is 0. After reset the counter holds zero, so the first enabled clock raises `pulse_o` for one cycle.
- R2: In wide mode (`narrow_i` = 0) with period value D (1..16383), `pulse_o` is high for one cycle in every D + 1 enabled clocks.
- R3: In narrow mode (`narrow_i` = 1), only `period_i[7:0]` sets the period, and bits 13:8 have no effect on pulse spacing.
- R4: A period value that is zero in the active width is treated as 1, which gives a pulse every 2 enabled clocks.
- R5: While `en_i` is 0 and no restart occurs, the count is frozen and `pulse_o` stays 0. Counting resumes where it stopped.
- R6: With `edge_sel_i` = 2'b00, changes on `restart_i` have no effect on pulse timing.
- R7: With `edge_sel_i` = 2'b01, a rising edge on `restart_i` raises `pulse_o` at the third clock edge after the change. The following pulse comes D + 1 clocks later. Falling edges are ignored.
- R8: With `edge_sel_i` = 2'b10, only falling edges restart. With 2'b11, both edges restart.
- R9: A change of `period_i` takes effect at the next reload or restart. The period already in progress keeps its old length.
- R10: A selected restart edge acts even while `en_i` is 0. It gives its one-cycle pulse, and the count then stays frozen until `en_i` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| en_i | input | 1 | Count enable |
| period_i | input | 14 | Period value D; output period is D + 1 clocks |
| narrow_i | input | 1 | 1 selects 8-bit period mode |
| edge_sel_i | input | 2 | Restart edge select: 00 off, 01 rising, 10 falling, 11 both |
| restart_i | input | 1 | Asynchronous restart input |
| pulse_o | output | 1 | One-cycle period pulse |

## Verification
The divider is run with short, mid-sized, minimum and full-scale wide periods. It is also run with narrow values whose upper bits are set, which shows whether masking is done before or after the zero clamp. Restart edges are applied a few cycles into a period under each of the four select codes. Both edge polarities are tried under each code, so an inverted or missing edge term shows up as a pulse gap of 3 where the full remainder was expected, or the reverse. Enable gaps, a restart during a gap, and a period change in mid-count separate freezing, priority and reload-time sampling from one another.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  localparam int unsigned WIDE_W   = 14;
  localparam int unsigned NARROW_W = 8;

  localparam logic [WIDE_W-1:0] NARROW_MASK =
    {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  typedef enum logic [1:0] {
    RST_OFF  = 2'b00,
    RST_RISE = 2'b01,
    RST_FALL = 2'b10,
    RST_BOTH = 2'b11
  } rst_edge_e;

  // Period value actually loaded: masked to the active width, zero lifted to one.
  function automatic logic [WIDE_W-1:0] eff_period(
    input logic [WIDE_W-1:0] raw,
    input logic              narrow
  );
    logic [WIDE_W-1:0] m;
    m = narrow ? (raw & NARROW_MASK) : raw;
    if (m == '0) m = {{(WIDE_W-1){1'b0}}, 1'b1};
    return m;
  endfunction

  // Next count value on an ordinary down step.
  function automatic logic [WIDE_W-1:0] step_down(input logic [WIDE_W-1:0] cur);
    return cur - {{(WIDE_W-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/cdiv_sync.sv
module cdiv_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= 1'b0;
        else         chain_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= 1'b0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cdiv_edge_sel.sv
module cdiv_edge_sel
  import cdiv_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  rst_edge_e mode_i,
  output logic      evt_o
);

  logic hist_q;
  logic rise_seen;
  logic fall_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= 1'b0;
    else         hist_q <= lvl_i;
  end

  assign rise_seen = lvl_i & ~hist_q;
  assign fall_seen = ~lvl_i & hist_q;

  always_comb begin
    unique case (mode_i)
      RST_RISE: evt_o = rise_seen;
      RST_FALL: evt_o = fall_seen;
      RST_BOTH: evt_o = rise_seen | fall_seen;
      default:  evt_o = 1'b0;
    endcase
  end

  AST_OFF_NO_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == RST_OFF) |-> !evt_o); // R6
  AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (lvl_i != hist_q)); // R7
  AST_RISE_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && mode_i == RST_RISE) |-> lvl_i); // R7
  AST_FALL_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && mode_i == RST_FALL) |-> !lvl_i); // R8

endmodule

// File: rtl/cdiv_down_counter.sv
module cdiv_down_counter
  import cdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic [WIDE_W-1:0] period_i,
  input  logic              narrow_i,
  output logic              pulse_o
);

  logic [WIDE_W-1:0] cnt_q;
  logic [WIDE_W-1:0] load_val;
  logic              at_zero;
  logic              load_strobe;
  logic              step_strobe;
  logic              pulse_q;

  assign load_val    = eff_period(period_i, narrow_i);
  assign at_zero     = (cnt_q == '0);
  assign load_strobe = restart_i | (en_i & at_zero);
  assign step_strobe = en_i & ~restart_i & ~at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (load_strobe) begin
      cnt_q   <= load_val;
      pulse_q <= 1'b1;
    end else begin
      if (step_strobe) cnt_q <= step_down(cnt_q);
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;

  AST_RESTART_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pulse_o && cnt_q == $past(load_val))); // R7
  AST_TERMINAL_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !restart_i && cnt_q == '0) |=> pulse_o); // R2
  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !restart_i && cnt_q != '0) |=> (!pulse_o && cnt_q == $past(cnt_q) - 1'b1)); // R2
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !restart_i) |=> (!pulse_o && $stable(cnt_q))); // R5
  AST_NARROW_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_strobe && narrow_i) |=> (cnt_q <= WIDE_W'(NARROW_MASK))); // R3
  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_strobe |=> (cnt_q != '0)); // R4

endmodule

// File: rtl/cdiv_period_gen.sv
module cdiv_period_gen
  import cdiv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WIDE_W-1:0] period_i,
  input  logic              narrow_i,
  input  logic [1:0]        edge_sel_i,
  input  logic              restart_i,
  output logic              pulse_o
);

  logic      restart_lvl;
  logic      restart_evt;
  rst_edge_e edge_mode;

  assign edge_mode = rst_edge_e'(edge_sel_i);

  cdiv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (restart_i),
    .q_o    (restart_lvl)
  );

  cdiv_edge_sel u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (restart_lvl),
    .mode_i (edge_mode),
    .evt_o  (restart_evt)
  );

  cdiv_down_counter u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .restart_i (restart_evt),
    .period_i  (period_i),
    .narrow_i  (narrow_i),
    .pulse_o   (pulse_o)
  );

  AST_RESTART_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_evt && !en_i) |=> pulse_o); // R10

endmodule

// File: tb/cdiv_period_gen_tb.sv
`timescale 1ns/1ps
module cdiv_period_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [13:0] period = 14'd5;
  logic        narrow = 1'b0;
  logic [1:0]  esel = 2'b00;
  logic        rstin = 1'b0;
  logic        pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cdiv_period_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .period_i(period),
    .narrow_i(narrow), .edge_sel_i(esel), .restart_i(rstin), .pulse_o(pulse)
  );

  function automatic int exp_gap(input int d, input bit nar);
    int v;
    v = nar ? (d % 256) : (d % 16384);
    if (v == 0) v = 1;
    return v + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles_to_pulse(output int n);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      n++;
      if (pulse) return;
    end
  endtask

  task automatic sync_pulse();
    int n;
    cycles_to_pulse(n);
  endtask

  task automatic idle_low(input int k, input string req);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      check(pulse == 1'b0, req, pulse, 0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(pulse == 1'b0, "R1 in reset", pulse, 0);
    rst_n = 1'b1;
    idle_low(3, "R1 idle after reset");
    en = 1'b1;
    @(negedge clk);
    check(pulse == 1'b1, "R1 first enabled pulse", pulse, 1);
    @(negedge clk);
    check(pulse == 1'b0, "R1 pulse width", pulse, 0);
  endtask

  task automatic t_period(input int d, input bit nar, input string req);
    int n;
    period = d[13:0];
    narrow = nar;
    sync_pulse();
    @(negedge clk);
    check(pulse == 1'b0, {req, " width"}, pulse, 0);
    cycles_to_pulse(n);
    check(n == exp_gap(d, nar) - 1, req, n + 1, exp_gap(d, nar));
    cycles_to_pulse(n);
    check(n == exp_gap(d, nar), req, n, exp_gap(d, nar));
  endtask

  task automatic t_enable();
    int n;
    period = 14'd9; narrow = 1'b0;
    sync_pulse(); sync_pulse();
    idle_low(3, "R5 running");
    en = 1'b0;
    idle_low(7, "R5 frozen");
    en = 1'b1;
    cycles_to_pulse(n);
    check(n == 7, "R5 resume", n, 7);
  endtask

  // After a pulse, wait 4 cycles, move restart_i to lvl, then measure gap.
  task automatic edge_try(input logic lvl, input bit acts, input string req);
    int n;
    sync_pulse();
    for (int i = 0; i < 4; i++) @(negedge clk);
    rstin = lvl;
    cycles_to_pulse(n);
    if (acts) check(n == 3, req, n, 3);
    else      check(n == 17, req, n, 17);
    if (acts) begin
      cycles_to_pulse(n);
      check(n == 21, {req, " following period"}, n, 21);
    end
  endtask

  task automatic t_edges();
    period = 14'd20; narrow = 1'b0;
    esel = 2'b00;
    edge_try(1'b1, 1'b0, "R6 off rise");
    edge_try(1'b0, 1'b0, "R6 off fall");
    esel = 2'b01;
    edge_try(1'b1, 1'b1, "R7 rising acts");
    edge_try(1'b0, 1'b0, "R7 falling ignored");
    esel = 2'b10;
    edge_try(1'b1, 1'b0, "R8 rise ignored");
    edge_try(1'b0, 1'b1, "R8 falling acts");
    esel = 2'b11;
    edge_try(1'b1, 1'b1, "R8 both rise");
    edge_try(1'b0, 1'b1, "R8 both fall");
  endtask

  task automatic t_restart_disabled();
    int n;
    period = 14'd6; esel = 2'b01;
    sync_pulse();
    en = 1'b0;
    rstin = 1'b1;
    @(negedge clk); @(negedge clk);
    check(pulse == 1'b0, "R10 before restart", pulse, 0);
    @(negedge clk);
    check(pulse == 1'b1, "R10 restart while disabled", pulse, 1);
    idle_low(5, "R10 frozen after restart");
    en = 1'b1;
    cycles_to_pulse(n);
    check(n == 7, "R10 resume full period", n, 7);
    rstin = 1'b0;
    esel = 2'b00;
  endtask

  task automatic t_change();
    int n;
    period = 14'd30; narrow = 1'b0;
    sync_pulse(); sync_pulse();
    for (int i = 0; i < 5; i++) @(negedge clk);
    period = 14'd8;
    cycles_to_pulse(n);
    check(n == 26, "R9 old period kept", n + 5, 31);
    cycles_to_pulse(n);
    check(n == 9, "R9 new period used", n, 9);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_period(5, 1'b0, "R2 D=5");
    t_period(37, 1'b0, "R2 D=37");
    t_period(1, 1'b0, "R2 D=1");
    t_period(16383, 1'b0, "R2 D=max");
    t_period(16'h1F05, 1'b1, "R3 narrow masked");
    t_period(16'h3FC8, 1'b1, "R3 narrow upper bits");
    t_period(16'h0100, 1'b1, "R4 narrow zero");
    t_period(0, 1'b0, "R4 wide zero");
    t_enable();
    t_edges();
    t_restart_disabled();
    t_change();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule